// File: doc/BRIEF.md
# Hardware Call Stack with Frame Reservation

This block is a fixed-depth last-in first-out store that serves a small processor core for data pushes and pops and for subroutine linkage. The core's decoder presents one command per cycle. The command carries a source value, which is either an immediate or a register operand, a destination register index, the current program counter and a branch target. The block answers with a register-file write request, a program-counter load request and three error pulses. The stack pointer, empty and full are visible at all times.

A subroutine call takes two commands. A frame-reserve command claims one slot and fills it with a zero placeholder. The core may then push parameters above that slot. A later call command writes the address of the instruction after the call into the most recent slot that is still unfilled, and redirects the program counter to the target. A return pops the top entry into the program counter. The stack grows upward. Illegal commands change nothing and raise an error pulse instead.

Top module: `call_stack_unit`

## Requirements
- R1: While `rst_n` is low at a clock edge, the stack pointer becomes 0, `stk_empty` becomes 1, and every request and error output becomes 0.
- R2: A push command (`cmd_op` = 1) on a stack that is not full stores `imm_data` when `src_is_imm` is 1, or `reg_data` when it is 0, and raises the pointer by one.
- R3: A pop command (`cmd_op` = 2) on a stack that is not empty lowers the pointer by one. It also pulses `rf_we` for one cycle, with `rf_data` set to the top entry and `rf_idx` set to `dst_idx`. Entries leave in reverse order of entry.
- R4: A pop or return (`cmd_op` = 5) on an empty stack pulses `err_underflow`, issues no write and no program-counter load, and leaves the pointer at 0.
- R5: The stack holds DEPTH (16) entries. A push or frame-reserve on a full stack pulses `err_overflow` and leaves the pointer and the contents unchanged.
- R6: A frame-reserve command (`cmd_op` = 3) on a stack that is not full raises the pointer by one and places a zero placeholder in the claimed slot.
- R7: A call command (`cmd_op` = 4) writes `cur_pc`+1 (modulo 2^PC_W, zero-extended) into the highest reserved slot that has not yet been filled. Entries pushed above that slot are left alone. The call pulses `pc_load` with `pc_value` = `tgt_pc` and leaves the pointer unchanged.
- R8: A call with no unfilled reserved slot on the stack pulses `err_frame`, issues no program-counter load, and leaves the pointer and the contents unchanged.
- R9: A return on a stack that is not empty lowers the pointer by one and pulses `pc_load` with `pc_value` set to the low PC_W bits of the top entry.
- R10: A reserved slot that is removed by a pop or a return before any call fills it no longer counts as reserved.
- R11: A command has no effect when `cmd_valid` is low, or when `cmd_op` holds 0, 6 or 7.
- R12: Every request and error output is registered. It appears in the cycle after the command's clock edge and lasts one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_valid | input | 1 | Command present this cycle |
| cmd_op | input | 3 | Command code: 0 none, 1 push, 2 pop, 3 reserve frame, 4 call, 5 return |
| src_is_imm | input | 1 | Push source select: 1 immediate, 0 register |
| imm_data | input | DATA_W | Immediate push value |
| reg_data | input | DATA_W | Register operand push value |
| dst_idx | input | REG_IDX_W | Destination register for a pop |
| cur_pc | input | PC_W | Address of the current instruction |
| tgt_pc | input | PC_W | Subroutine target of a call |
| rf_we | output | 1 | Register-file write request |
| rf_idx | output | REG_IDX_W | Register-file write index |
| rf_data | output | DATA_W | Register-file write data |
| pc_load | output | 1 | Program-counter load request |
| pc_value | output | PC_W | New program-counter value |
| sp_out | output | $clog2(DEPTH)+1 | Stack pointer (number of entries) |
| stk_empty | output | 1 | Stack holds no entry |
| stk_full | output | 1 | Stack holds DEPTH entries |
| err_underflow | output | 1 | Pop or return on an empty stack |
| err_overflow | output | 1 | Push or reserve on a full stack |
| err_frame | output | 1 | Call without an unfilled reserved slot |

## Verification
The bench places a parameter between the reserved slot and the call. A design that fills the top of the stack instead of the reserved slot would return to the parameter's value and pop the return address into a register. Nested calls check that the most recent unfilled reservation is the one taken. A reservation removed by a pop before the call must give a frame error, and a design that kept stale reservation marks would jump instead. The bench also fills the stack to its exact depth and pushes past it, and pops and returns on an empty stack. Any pointer movement, write or load in those cases shows up as a mismatch against the bench's model.

// File: rtl/cstk_pkg.sv
// Package: command codes and the decoded action set shared by the stack blocks.
// Assumes cmd_op is sampled only while cmd_valid is high.
package cstk_pkg;

    typedef enum logic [2:0] {
        OP_NOP  = 3'd0,
        OP_PUSH = 3'd1,
        OP_POP  = 3'd2,
        OP_MARK = 3'd3,
        OP_CALL = 3'd4,
        OP_RET  = 3'd5
    } stk_op_e;

    // One bit per action the datapath may take in a cycle
    typedef struct packed {
        logic push;
        logic pop;
        logic mark;
        logic call;
        logic ret;
        logic ovf;
        logic unf;
        logic ferr;
    } stk_act_t;

endpackage

// File: rtl/cstk_decode.sv
// Decoder: turns a command and the stack state into legal actions or errors.
// Assumes full and empty are never both high. Codes 0, 6 and 7 decode to nothing.
module cstk_decode
    import cstk_pkg::*;
(
    input  logic     cmd_valid,
    input  logic [2:0] cmd_op,
    input  logic     full,
    input  logic     empty,
    input  logic     pend_hit,
    output stk_act_t act
);

    // Classify the command against full/empty/pending-slot conditions
    always_comb begin
        act = '0;
        if (cmd_valid) begin
            case (cmd_op)
                OP_PUSH: begin
                    act.push = !full;
                    act.ovf  = full;
                end
                OP_MARK: begin
                    act.mark = !full;
                    act.ovf  = full;
                end
                OP_POP: begin
                    act.pop  = !empty;
                    act.unf  = empty;
                end
                OP_RET: begin
                    act.ret  = !empty;
                    act.unf  = empty;
                end
                OP_CALL: begin
                    act.call = pend_hit;
                    act.ferr = !pend_hit;
                end
                default: act = '0;
            endcase
        end
    end

endmodule

// File: rtl/cstk_ptr.sv
// Stack pointer: counts stored entries (0..DEPTH) and flags full/empty.
// Assumes the caller never asserts inc when full or dec when empty.
module cstk_ptr #(
    parameter int DEPTH = 16,
    localparam int PTR_W = $clog2(DEPTH) + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             inc,
    input  logic             dec,
    output logic [PTR_W-1:0] sp,
    output logic             full,
    output logic             empty
);

    localparam logic [PTR_W-1:0] ONE   = PTR_W'(1);
    localparam logic [PTR_W-1:0] LIMIT = PTR_W'(DEPTH);

    // Move the pointer up on a store, down on a removal
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sp <= '0;
        end else if (inc && !dec) begin
            sp <= sp + ONE;
        end else if (dec && !inc) begin
            sp <= sp - ONE;
        end
    end

    // Derive occupancy flags from the count
    always_comb begin
        full  = (sp == LIMIT);
        empty = (sp == '0);
    end

endmodule

// File: rtl/cstk_frame.sv
// Frame tracker: one bit per slot marks a reserved slot that no call has filled.
// Finds the highest such slot below the pointer. Assumes set, clear-top and fill
// never name the same slot in one cycle (the decoder allows one action per cycle).
module cstk_frame #(
    parameter int DEPTH = 16,
    localparam int IDX_W = $clog2(DEPTH),
    localparam int PTR_W = IDX_W + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [PTR_W-1:0] sp,
    input  logic             set_en,
    input  logic             clr_top_en,
    input  logic             fill_en,
    output logic             hit,
    output logic [IDX_W-1:0] hit_idx
);

    logic [DEPTH-1:0] pend;
    logic [IDX_W-1:0] new_idx;
    logic [IDX_W-1:0] top_idx;

    // Slot claimed by a reserve, and slot removed by a pop or return
    always_comb begin
        new_idx = sp[IDX_W-1:0];
        top_idx = sp[IDX_W-1:0] - IDX_W'(1);
    end

    // Priority search: the highest pending slot under the pointer wins
    always_comb begin
        hit     = 1'b0;
        hit_idx = '0;
        for (int i = 0; i < DEPTH; i++) begin
            if (pend[i] && (PTR_W'(i) < sp)) begin
                hit     = 1'b1;
                hit_idx = IDX_W'(i);
            end
        end
    end

    // Maintain pending marks on reserve, fill and removal
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend <= '0;
        end else begin
            if (set_en) begin
                pend[new_idx] <= 1'b1;
            end
            if (clr_top_en) begin
                pend[top_idx] <= 1'b0;
            end
            if (fill_en) begin
                pend[hit_idx] <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/cstk_store.sv
// Entry storage: DEPTH words, one write port, one asynchronous read port.
// Assumes contents are meaningful only below the pointer, so the array has no reset.
module cstk_store #(
    parameter int DEPTH  = 16,
    parameter int DATA_W = 16,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              we,
    input  logic [IDX_W-1:0]  waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [IDX_W-1:0]  raddr,
    output logic [DATA_W-1:0] rdata
);

    logic [DATA_W-1:0] mem [DEPTH];

    // Write one entry per cycle
    always_ff @(posedge clk) begin
        if (we) begin
            mem[waddr] <= wdata;
        end
    end

    // Read the addressed entry combinationally
    always_comb begin
        rdata = mem[raddr];
    end

endmodule

// File: rtl/call_stack_unit.sv
// Call stack top: pushes, pops, two-step call (reserve then fill) and return.
// Assumes PC_W <= DATA_W and one command per cycle from the decoder. All request
// and error outputs are registered one-cycle pulses.
module call_stack_unit
    import cstk_pkg::*;
#(
    parameter int DEPTH     = 16,
    parameter int DATA_W    = 16,
    parameter int PC_W      = 12,
    parameter int REG_IDX_W = 5
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    cmd_valid,
    input  logic [2:0]              cmd_op,
    input  logic                    src_is_imm,
    input  logic [DATA_W-1:0]       imm_data,
    input  logic [DATA_W-1:0]       reg_data,
    input  logic [REG_IDX_W-1:0]    dst_idx,
    input  logic [PC_W-1:0]         cur_pc,
    input  logic [PC_W-1:0]         tgt_pc,
    output logic                    rf_we,
    output logic [REG_IDX_W-1:0]    rf_idx,
    output logic [DATA_W-1:0]       rf_data,
    output logic                    pc_load,
    output logic [PC_W-1:0]         pc_value,
    output logic [$clog2(DEPTH):0]  sp_out,
    output logic                    stk_empty,
    output logic                    stk_full,
    output logic                    err_underflow,
    output logic                    err_overflow,
    output logic                    err_frame
);

    localparam int IDX_W = $clog2(DEPTH);
    localparam int PTR_W = IDX_W + 1;

    stk_act_t          act;
    logic [PTR_W-1:0]  sp;
    logic              full;
    logic              empty;
    logic              pend_hit;
    logic [IDX_W-1:0]  pend_idx;
    logic              st_we;
    logic [IDX_W-1:0]  st_waddr;
    logic [DATA_W-1:0] st_wdata;
    logic [IDX_W-1:0]  top_idx;
    logic [DATA_W-1:0] top_data;
    logic [PC_W-1:0]   ret_addr;

    cstk_decode u_dec (
        .cmd_valid (cmd_valid),
        .cmd_op    (cmd_op),
        .full      (full),
        .empty     (empty),
        .pend_hit  (pend_hit),
        .act       (act)
    );

    cstk_ptr #(.DEPTH(DEPTH)) u_ptr (
        .clk   (clk),
        .rst_n (rst_n),
        .inc   (act.push | act.mark),
        .dec   (act.pop | act.ret),
        .sp    (sp),
        .full  (full),
        .empty (empty)
    );

    cstk_frame #(.DEPTH(DEPTH)) u_frame (
        .clk        (clk),
        .rst_n      (rst_n),
        .sp         (sp),
        .set_en     (act.mark),
        .clr_top_en (act.pop | act.ret),
        .fill_en    (act.call),
        .hit        (pend_hit),
        .hit_idx    (pend_idx)
    );

    cstk_store #(.DEPTH(DEPTH), .DATA_W(DATA_W)) u_store (
        .clk   (clk),
        .we    (st_we),
        .waddr (st_waddr),
        .wdata (st_wdata),
        .raddr (top_idx),
        .rdata (top_data)
    );

    // Select the storage write: push value, zero placeholder, or return address
    always_comb begin
        ret_addr = cur_pc + PC_W'(1);
        top_idx  = sp[IDX_W-1:0] - IDX_W'(1);
        st_we    = act.push | act.mark | act.call;
        st_waddr = act.call ? pend_idx : sp[IDX_W-1:0];
        if (act.push) begin
            st_wdata = src_is_imm ? imm_data : reg_data;
        end else if (act.call) begin
            st_wdata = DATA_W'(ret_addr);
        end else begin
            st_wdata = '0;
        end
    end

    // Register the request and error pulses
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rf_we         <= 1'b0;
            rf_idx        <= '0;
            rf_data       <= '0;
            pc_load       <= 1'b0;
            pc_value      <= '0;
            err_underflow <= 1'b0;
            err_overflow  <= 1'b0;
            err_frame     <= 1'b0;
        end else begin
            rf_we         <= act.pop;
            rf_idx        <= act.pop ? dst_idx : '0;
            rf_data       <= act.pop ? top_data : '0;
            pc_load       <= act.call | act.ret;
            if (act.call) begin
                pc_value <= tgt_pc;
            end else if (act.ret) begin
                pc_value <= top_data[PC_W-1:0];
            end else begin
                pc_value <= '0;
            end
            err_underflow <= act.unf;
            err_overflow  <= act.ovf;
            err_frame     <= act.ferr;
        end
    end

    // Expose pointer state
    always_comb begin
        sp_out    = sp;
        stk_empty = empty;
        stk_full  = full;
    end

endmodule

// File: rtl/cstk_chk.sv
// Checker: temporal properties of the call stack, seen at its ports.
// Assumes it is bound to call_stack_unit and reset is held for at least two clocks.
module cstk_chk
    import cstk_pkg::*;
#(
    parameter int DEPTH = 16,
    localparam int PTR_W = $clog2(DEPTH) + 1
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cmd_valid,
    input logic [2:0]       cmd_op,
    input logic             rf_we,
    input logic             pc_load,
    input logic [PTR_W-1:0] sp_out,
    input logic             stk_empty,
    input logic             stk_full,
    input logic             err_underflow,
    input logic             err_overflow,
    input logic             err_frame
);

    // R2
    push_grows_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_op == OP_PUSH && !stk_full) |=> (sp_out == $past(sp_out) + 1'b1));

    // R3
    pop_writes_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_op == OP_POP && !stk_empty) |=> (rf_we && sp_out == $past(sp_out) - 1'b1));

    // R4
    no_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        err_underflow |-> (!rf_we && !pc_load && stk_empty));

    // R5
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        err_overflow |-> (stk_full && sp_out == $past(sp_out)));

    // R8
    frame_err_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        err_frame |-> (!pc_load && sp_out == $past(sp_out)));

    // R9
    ret_loads_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_op == OP_RET && !stk_empty) |=> (pc_load && sp_out == $past(sp_out) - 1'b1));

    // R11
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cmd_valid |=> ($stable(sp_out) && !rf_we && !pc_load
                        && !err_underflow && !err_overflow && !err_frame));

    // R12
    one_error_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({err_underflow, err_overflow, err_frame, rf_we, pc_load}));

endmodule

bind call_stack_unit cstk_chk #(.DEPTH(DEPTH)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .cmd_valid     (cmd_valid),
    .cmd_op        (cmd_op),
    .rf_we         (rf_we),
    .pc_load       (pc_load),
    .sp_out        (sp_out),
    .stk_empty     (stk_empty),
    .stk_full      (stk_full),
    .err_underflow (err_underflow),
    .err_overflow  (err_overflow),
    .err_frame     (err_frame)
);

// File: tb/tb_call_stack_unit.sv
// Directed bench: a behavioural model built from the requirements predicts every output.
module tb_call_stack_unit;

    localparam int CLK_P = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_valid = 1'b0;
    logic [2:0]  cmd_op = 3'd0;
    logic        src_is_imm = 1'b0;
    logic [15:0] imm_data = '0;
    logic [15:0] reg_data = '0;
    logic [4:0]  dst_idx = '0;
    logic [11:0] cur_pc = '0;
    logic [11:0] tgt_pc = '0;
    logic        rf_we;
    logic [4:0]  rf_idx;
    logic [15:0] rf_data;
    logic        pc_load;
    logic [11:0] pc_value;
    logic [4:0]  sp_out;
    logic        stk_empty, stk_full;
    logic        err_underflow, err_overflow, err_frame;

    int n_chk = 0;
    int n_err = 0;

    logic [15:0] m_mem [16];
    bit          m_pend [16];
    int          m_sp = 0;

    call_stack_unit dut (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .src_is_imm(src_is_imm), .imm_data(imm_data), .reg_data(reg_data),
        .dst_idx(dst_idx), .cur_pc(cur_pc), .tgt_pc(tgt_pc),
        .rf_we(rf_we), .rf_idx(rf_idx), .rf_data(rf_data),
        .pc_load(pc_load), .pc_value(pc_value), .sp_out(sp_out),
        .stk_empty(stk_empty), .stk_full(stk_full),
        .err_underflow(err_underflow), .err_overflow(err_overflow), .err_frame(err_frame)
    );

    always #(CLK_P/2) clk = ~clk;

    task automatic chk(input string tag, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    task automatic chk_state(input string tag);
        chk(tag, "sp", int'(sp_out), m_sp);
        chk(tag, "empty", int'(stk_empty), int'(m_sp == 0));
        chk(tag, "full", int'(stk_full), int'(m_sp == 16));
    endtask

    // Issue one command, predict its effect from the model and compare
    task automatic do_op(input logic [2:0] op, input logic isimm, input logic [15:0] imm,
                         input logic [15:0] rv, input logic [4:0] dst, input logic [11:0] pc,
                         input logic [11:0] tgt, input string tag);
        logic e_we = 0, e_pl = 0, e_uf = 0, e_of = 0, e_fe = 0;
        logic [15:0] e_wd = '0;
        logic [11:0] e_pv = '0;
        int hit = -1;
        for (int i = 0; i < m_sp; i++) if (m_pend[i]) hit = i;
        case (op)
            3'd1: if (m_sp == 16) e_of = 1;
                  else begin m_mem[m_sp] = isimm ? imm : rv; m_pend[m_sp] = 0; m_sp++; end
            3'd2: if (m_sp == 0) e_uf = 1;
                  else begin m_sp--; e_we = 1; e_wd = m_mem[m_sp]; m_pend[m_sp] = 0; end
            3'd3: if (m_sp == 16) e_of = 1;
                  else begin m_mem[m_sp] = '0; m_pend[m_sp] = 1; m_sp++; end
            3'd4: if (hit < 0) e_fe = 1;
                  else begin
                      m_mem[hit] = {4'h0, pc + 12'd1}; m_pend[hit] = 0;
                      e_pl = 1; e_pv = tgt;
                  end
            3'd5: if (m_sp == 0) e_uf = 1;
                  else begin m_sp--; e_pl = 1; e_pv = m_mem[m_sp][11:0]; m_pend[m_sp] = 0; end
            default: ;
        endcase
        cmd_valid = 1'b1; cmd_op = op; src_is_imm = isimm; imm_data = imm;
        reg_data = rv; dst_idx = dst; cur_pc = pc; tgt_pc = tgt;
        @(posedge clk);
        #1;
        cmd_valid = 1'b0;
        chk(tag, "rf_we", int'(rf_we), int'(e_we));
        if (e_we) begin
            chk(tag, "rf_data", int'(rf_data), int'(e_wd));
            chk(tag, "rf_idx", int'(rf_idx), int'(dst));
        end
        chk(tag, "pc_load", int'(pc_load), int'(e_pl));
        if (e_pl) chk(tag, "pc_value", int'(pc_value), int'(e_pv));
        chk(tag, "err_underflow", int'(err_underflow), int'(e_uf));
        chk(tag, "err_overflow", int'(err_overflow), int'(e_of));
        chk(tag, "err_frame", int'(err_frame), int'(e_fe));
        chk_state(tag);
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) @(posedge clk);
        #1;
        rst_n = 1'b1;
        m_sp = 0;
        for (int i = 0; i < 16; i++) m_pend[i] = 0;
        chk_state("R1");
        chk("R1", "rf_we", int'(rf_we), 0);
        chk("R1", "pc_load", int'(pc_load), 0);
        chk("R1", "errors", int'({err_underflow, err_overflow, err_frame}), 0);
    endtask

    task automatic t_push_pop();
        do_op(3'd1, 1, 16'h1234, 16'h0, 0, 0, 0, "R2");
        do_op(3'd1, 0, 16'h0, 16'hBEEF, 0, 0, 0, "R2");
        do_op(3'd1, 1, 16'hFFFE, 16'h5555, 0, 0, 0, "R2");
        do_op(3'd2, 0, 0, 0, 5'd7, 0, 0, "R3");
        do_op(3'd2, 0, 0, 0, 5'd31, 0, 0, "R3");
        do_op(3'd2, 0, 0, 0, 5'd2, 0, 0, "R3");
    endtask

    task automatic t_underflow();
        do_op(3'd2, 0, 0, 0, 5'd3, 0, 0, "R4");
        do_op(3'd5, 0, 0, 0, 0, 0, 0, "R4");
    endtask

    task automatic t_overflow();
        for (int i = 0; i < 16; i++) do_op(3'd1, 1, 16'(i * 7 + 3), 0, 0, 0, 0, "R5");
        do_op(3'd1, 1, 16'hAAAA, 0, 0, 0, 0, "R5");
        do_op(3'd3, 0, 0, 0, 0, 0, 0, "R5");
        for (int i = 0; i < 16; i++) do_op(3'd2, 0, 0, 0, 5'(i), 0, 0, "R3");
    endtask

    task automatic t_call_ret();
        do_op(3'd3, 0, 0, 0, 0, 0, 0, "R6");
        do_op(3'd1, 1, 16'd8, 0, 0, 0, 0, "R2");
        do_op(3'd4, 0, 0, 0, 0, 12'd100, 12'd200, "R7");
        do_op(3'd2, 0, 0, 0, 5'd2, 0, 0, "R7");
        do_op(3'd5, 0, 0, 0, 0, 0, 0, "R9");
        do_op(3'd3, 0, 0, 0, 0, 0, 0, "R6");
        do_op(3'd4, 0, 0, 0, 0, 12'd10, 12'd50, "R7");
        do_op(3'd3, 0, 0, 0, 0, 0, 0, "R6");
        do_op(3'd4, 0, 0, 0, 0, 12'hFFF, 12'd80, "R7");
        do_op(3'd5, 0, 0, 0, 0, 0, 0, "R9");
        do_op(3'd5, 0, 0, 0, 0, 0, 0, "R9");
    endtask

    task automatic t_frame_err();
        do_op(3'd4, 0, 0, 0, 0, 12'd5, 12'd9, "R8");
        do_op(3'd3, 0, 0, 0, 0, 0, 0, "R6");
        do_op(3'd2, 0, 0, 0, 5'd4, 0, 0, "R6");
        do_op(3'd4, 0, 0, 0, 0, 12'd5, 12'd9, "R10");
        do_op(3'd3, 0, 0, 0, 0, 0, 0, "R6");
        do_op(3'd4, 0, 0, 0, 0, 12'd20, 12'd30, "R7");
        do_op(3'd4, 0, 0, 0, 0, 12'd21, 12'd31, "R8");
        do_op(3'd5, 0, 0, 0, 0, 0, 0, "R9");
    endtask

    task automatic t_idle();
        do_op(3'd1, 1, 16'h0042, 0, 0, 0, 0, "R2");
        cmd_valid = 1'b0; cmd_op = 3'd2;
        @(posedge clk);
        #1;
        chk("R11", "rf_we", int'(rf_we), 0);
        chk_state("R11");
        do_op(3'd7, 1, 16'h9999, 0, 0, 0, 0, "R11");
        do_op(3'd0, 1, 16'h9999, 0, 0, 0, 0, "R11");
        do_op(3'd2, 0, 0, 0, 5'd1, 0, 0, "R11");
        @(posedge clk);
        #1;
        chk("R12", "rf_we pulse ends", int'(rf_we), 0);
    endtask

    initial begin
        #(CLK_P * 200000);
        n_err++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end

    initial begin
        #1;
        t_reset();
        t_push_pop();
        t_underflow();
        t_overflow();
        t_call_ret();
        t_frame_err();
        t_idle();
        $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end

endmodule